// File: doc/BRIEF.md
# DMA-Aware Interrupt Aggregator

This block gathers the interrupt sources of a peripheral I/O chip into one level-sensitive request for a processor interrupt input. The lower source lines carry device interrupts. These are level signals, and they are reported exactly as they are driven. The upper source lines carry DMA event strobes. A strobe is captured into a status bit, and the bit stays set until software clears it.

Software uses a small register port. Address 0 selects status and address 1 selects the enable mask. Status bits are cleared by writing 0 to them. DMA positions belong to one of two classes. Informational events never stop a transfer, and they can be captured again as soon as they have been cleared. Error events hold the DMA-halt line of their position high until software clears the bit. The split between device lines and DMA lines, and the informational class vector, are parameters.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, status reads 0 when all sources are low, the mask reads 0, `irq_o` is low and every `dma_halt_o` bit is low.
- R2: A write with `reg_addr_i`=1 loads the mask from `reg_wdata_i`. A read with `reg_addr_i`=1 returns the mask and a read with `reg_addr_i`=0 returns status, both in the same cycle without wait states.
- R3: `irq_o` is high exactly when some status bit and the mask bit at the same position are both 1. A mask bit of 0 disables its source.
- R4: Status bits below `DMA_BASE` equal the live source input in the same cycle. A status write leaves them unchanged.
- R5: A high source bit at or above `DMA_BASE` sets its status bit on the next clock edge. The bit stays set after the source goes low.
- R6: A status write (`reg_addr_i`=0) clears each DMA status bit where `reg_wdata_i` is 0. Bits written with 1 keep their value.
- R7: If a DMA event and a clear of the same bit happen in the same cycle, the bit stays set.
- R8: An informational DMA bit (a 1 in `INFO_SEL`) never raises a halt. It is captured again when its event recurs after a clear.
- R9: For each error DMA position k, `dma_halt_o[k]` equals status bit `DMA_BASE+k`. The mask has no effect on halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Device levels (low part) and DMA event strobes (high part) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata_i | input | NSRC | Write data |
| reg_rdata_o | output | NSRC | Read data for the selected register |
| irq_o | output | 1 | Combined level interrupt |
| dma_halt_o | output | NSRC-DMA_BASE | Halt request for each DMA position |

## Verification
Device-line status, read data and `irq_o` follow their inputs combinationally, so their effect appears in the same cycle. DMA captures, clears, mask writes and halts take effect on the first clock edge after the stimulus. Each stimulus is applied half a period before an edge. Results are sampled 1 ns after that edge, with the write strobe already dropped and the address turned to status. Each sample therefore reflects exactly one edge of register update.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 32,
  parameter int DMA_BASE = 16,
  parameter logic [NSRC-1:0] INFO_SEL = 32'h00E3_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_i,
  input  logic                     reg_we_i,
  input  logic                     reg_addr_i,
  input  logic [NSRC-1:0]          reg_wdata_i,
  output logic [NSRC-1:0]          reg_rdata_o,
  output logic                     irq_o,
  output logic [NSRC-DMA_BASE-1:0] dma_halt_o
);
  localparam int NDMA = NSRC - DMA_BASE;
  localparam logic [NSRC-1:0] DMA_SEL = {{NDMA{1'b1}}, {DMA_BASE{1'b0}}};
  localparam logic [NSRC-1:0] ERR_SEL = DMA_SEL & ~INFO_SEL;

  logic [NSRC-1:0] dma_q, mask_q, status, clr;

  assign clr    = (reg_we_i && !reg_addr_i) ? ~reg_wdata_i : '0;
  assign status = (src_i & ~DMA_SEL) | dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_q  <= '0;
      mask_q <= '0;
    end else begin
      dma_q <= DMA_SEL & (src_i | (dma_q & ~clr));
      if (reg_we_i && reg_addr_i) mask_q <= reg_wdata_i;
    end
  end

  assign reg_rdata_o = reg_addr_i ? mask_q : status;
  assign irq_o       = |(status & mask_q);
  assign dma_halt_o  = status[NSRC-1:DMA_BASE] & ERR_SEL[NSRC-1:DMA_BASE];

  a_r5_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & DMA_SEL) != '0) |=> ((dma_q & $past(src_i & DMA_SEL)) == $past(src_i & DMA_SEL)));

  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_i && !reg_addr_i) |=> ((dma_q & $past(dma_q)) == $past(dma_q)));

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  a_r9_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_i && !reg_addr_i) |=> ((dma_halt_o & $past(dma_halt_o)) == $past(dma_halt_o)));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && dma_q == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  logic clk = 0, rst_n = 0, we = 0, addr = 0;
  logic [31:0] src = 0, wd = 0, rd;
  logic irq;
  logic [15:0] halt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_aggregator dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq), .dma_halt_o(halt));

  typedef struct packed {
    logic [31:0] src; logic we; logic addr; logic [31:0] wd;
    logic [31:0] st; logic irq; logic [15:0] halt; int rq;
  } vec_t;

  // info bits 16,17,21,22,23; error bits 18,19,20,24..31
  localparam vec_t VEC [14] = '{
    '{32'h0, 1, 1, 32'hFFFF_FFFF, 32'h0, 0, 16'h0, 2},               // R2 mask all on
    '{32'h1, 0, 0, 32'h0, 32'h1, 1, 16'h0, 4},                       // R4 live level
    '{32'h1, 1, 0, 32'h0, 32'h1, 1, 16'h0, 4},                       // R4 write cannot clear
    '{32'h0004_0000, 0, 0, 32'h0, 32'h0004_0000, 1, 16'h0004, 9},    // R9 error halts
    '{32'h0, 0, 0, 32'h0, 32'h0004_0000, 1, 16'h0004, 5},            // R5 held
    '{32'h0, 1, 0, 32'hFFFB_FFFF, 32'h0, 0, 16'h0, 6},               // R6 clear by zero
    '{32'h0001_0000, 0, 0, 32'h0, 32'h0001_0000, 1, 16'h0, 8},       // R8 info no halt
    '{32'h0001_0000, 1, 0, 32'hFFFE_FFFF, 32'h0001_0000, 1, 16'h0, 7}, // R7 event wins
    '{32'h0, 1, 0, 32'hFFFE_FFFF, 32'h0, 0, 16'h0, 6},               // R6 clear
    '{32'h0001_0000, 0, 0, 32'h0, 32'h0001_0000, 1, 16'h0, 8},       // R8 relatch
    '{32'h0, 1, 1, 32'h0, 32'h0001_0000, 0, 16'h0, 3},               // R3 masked off
    '{32'h0100_0000, 0, 0, 32'h0, 32'h0101_0000, 0, 16'h0100, 9},    // R9 mask no effect
    '{32'h0, 1, 0, 32'hFFFF_FFFF, 32'h0101_0000, 0, 16'h0100, 6},    // R6 ones keep
    '{32'h0, 1, 1, 32'h0100_0000, 32'h0101_0000, 1, 16'h0100, 3}     // R3 enable one
  };

  task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", rq, act, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    chk(1, {32'h0, rd}, 64'h0); chk(1, {63'h0, irq}, 64'h0); chk(1, {48'h0, halt}, 64'h0);
    addr = 1; #1 chk(1, {32'h0, rd}, 64'h0); addr = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      src = VEC[i].src; we = VEC[i].we; addr = VEC[i].addr; wd = VEC[i].wd;
      @(posedge clk); #1;
      we = 0; addr = 0; #0.1;
      chk(VEC[i].rq, {32'h0, rd}, {32'h0, VEC[i].st});
      chk(VEC[i].rq, {63'h0, irq}, {63'h0, VEC[i].irq});
      chk(VEC[i].rq, {48'h0, halt}, {48'h0, VEC[i].halt});
    end
    // R2 mask readback
    addr = 1; #0.1 chk(2, {32'h0, rd}, 64'h0100_0000); addr = 0;
    // R4 low line follows input same cycle, R3 disabled source stays quiet
    @(negedge clk) src = 32'h2; #0.1 chk(4, {32'h0, rd}, 64'h0101_0002);
    chk(3, {63'h0, irq}, 64'h1);
    // R1 mid-run reset
    @(negedge clk) begin rst_n = 0; src = 0; end
    @(posedge clk); #1 rst_n = 1;
    chk(1, {32'h0, rd}, 64'h0); chk(1, {48'h0, halt}, 64'h0);
    addr = 1; #0.1 chk(1, {32'h0, rd}, 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule